// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block sits beside a free-running timer counter and records when an external event happens. An asynchronous capture input is first brought into the clock domain through a short synchronizer. A selected transition on that input, rising or falling as chosen by a polarity control bit, copies the counter value present at that moment into a capture register. The same transition sets a sticky capture flag, and an interrupt request is raised while the flag is set and interrupts are enabled.

Software clears the flag with a single-cycle clear strobe. When the timer repurposes the capture register as its period limit, a mode input tells the unit, and the capture input is then ignored entirely. The counter, waveform generation and input filtering are handled elsewhere.

Top module: `edge_capture_unit`

## Requirements
- R1: With `rise_sel` = 0, a high-to-low transition of `cap_pin` triggers a capture; a low-to-high transition does not.
- R2: With `rise_sel` = 1, a low-to-high transition of `cap_pin` triggers a capture; a high-to-low transition does not.
- R3: A capture stores the `count_in` value present at the third rising clock edge after the pin transition (two synchronizer flops plus one edge-detect register); `cap_value` and `cap_flag` change on that same edge and not before.
- R4: A capture sets `cap_flag`; the flag then stays set until a cycle with `flag_clr` = 1, after which it reads 0 while `cap_value` is kept.
- R5: When a capture and `flag_clr` fall on the same clock edge, the capture wins and `cap_flag` stays 1.
- R6: `irq` is a registered output equal to the next flag value AND `irq_en`: it rises on the same edge as the flag when enabled, stays 0 while `irq_en` = 0, and follows a change of `irq_en` one edge later.
- R7: While `top_mode` = 1, transitions of `cap_pin` cause no capture: `cap_value` is unchanged and `cap_flag` is not set.
- R8: Changing `rise_sel` while `cap_pin` is steady causes no capture; the new polarity applies to the next transition.
- R9: After reset, `cap_value` is 0, `cap_flag` is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous capture input |
| count_in | input | CNT_W | Current timer counter value |
| rise_sel | input | 1 | Polarity: 1 = rising, 0 = falling |
| irq_en | input | 1 | Capture interrupt enable |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| top_mode | input | 1 | Capture register used as counter limit; capture disabled |
| cap_value | output | CNT_W | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| irq | output | 1 | Capture interrupt request |

## Verification
Every capture result is due on the third rising edge after the bench moves `cap_pin`, so the bench drives the pin and a distinct counter value on each falling edge and reads the outputs on the falling edge after the third rising edge, where the expected value is the counter driven in the third cycle. It also reads the flag after the second rising edge to confirm nothing arrives early. The interrupt is due on the same edge as the flag, and one edge after a change of `irq_en`; clear strobes are placed so the flag is read one edge after the strobe, and the race case puts the strobe on the very edge the capture lands.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam int unsigned ECU_CNT_W_DEF   = 16;
  localparam int unsigned ECU_SYNC_N_DEF  = 2;
  typedef enum logic {POL_FALL = 1'b0, POL_RISE = 1'b1} ecu_pol_e;
endpackage

// File: rtl/ecu_sync.sv
module ecu_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{IDLE_LVL}};
    else     chain_q <= {chain_q[STAGES-2:0], async_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ecu_edge.sv
module ecu_edge #(
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_in,
  input  ecu_pkg::ecu_pol_e pol,
  input  logic             gate_off,
  output logic             evt
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE_LVL;
    else     prev_q <= lvl_in;
  end

  // a transition whose new level matches the polarity is the wanted edge
  assign evt = (lvl_in != prev_q) && (lvl_in == logic'(pol)) && !gate_off;

  AST_EVT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
    evt |=> $past(lvl_in) != $past(prev_q)); // R8
endmodule

// File: rtl/ecu_store.sv
module ecu_store #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [CNT_W-1:0] count_in,
  input  logic             flag_clr,
  input  logic             irq_en,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = cap_flag;
    if (flag_clr) flag_nxt = 1'b0;
    if (evt)      flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (evt) cap_value <= count_in;
      cap_flag <= flag_nxt;
      irq      <= flag_nxt & irq_en;
    end
  end

  AST_FLAG_HOLDS:    assert property (@(posedge clk) disable iff (rst)
    cap_flag && !flag_clr |=> cap_flag); // R4
  AST_CLR_DROPS:     assert property (@(posedge clk) disable iff (rst)
    flag_clr && !evt |=> !cap_flag); // R4
  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt |=> cap_flag); // R5
  AST_IRQ_NEEDS_EN:  assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en)); // R6
  AST_VALUE_ON_EVT:  assert property (@(posedge clk) disable iff (rst)
    !evt |=> $stable(cap_value)); // R3
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int unsigned CNT_W    = ecu_pkg::ECU_CNT_W_DEF,
  parameter int unsigned SYNC_N   = ecu_pkg::ECU_SYNC_N_DEF,
  parameter logic        IDLE_LVL = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] count_in,
  input  logic             rise_sel,
  input  logic             irq_en,
  input  logic             flag_clr,
  input  logic             top_mode,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  logic              pin_s;
  logic              evt;
  ecu_pkg::ecu_pol_e pol;

  assign pol = rise_sel ? ecu_pkg::POL_RISE : ecu_pkg::POL_FALL;

  ecu_sync #(.STAGES(SYNC_N), .IDLE_LVL(IDLE_LVL)) u_sync (
    .clk(clk), .rst(rst), .async_in(cap_pin), .sync_out(pin_s));

  ecu_edge #(.IDLE_LVL(IDLE_LVL)) u_edge (
    .clk(clk), .rst(rst), .lvl_in(pin_s), .pol(pol),
    .gate_off(top_mode), .evt(evt));

  ecu_store #(.CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .evt(evt), .count_in(count_in),
    .flag_clr(flag_clr), .irq_en(irq_en),
    .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq));

  AST_TOP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    top_mode |=> $stable(cap_value)); // R7
  AST_TOP_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    top_mode && !cap_flag |=> !cap_flag); // R7
endmodule

// File: tb/tb_edge_capture_unit.sv
module tb_edge_capture_unit;
  localparam int CLK_P = 10;
  localparam int W     = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cap_pin = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         rise_sel = 1'b1;
  logic         irq_en = 1'b1;
  logic         flag_clr = 1'b0;
  logic         top_mode = 1'b0;
  logic [W-1:0] cap_value;
  logic         cap_flag;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  edge_capture_unit #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .cap_pin(cap_pin), .count_in(cnt),
    .rise_sel(rise_sel), .irq_en(irq_en), .flag_clr(flag_clr),
    .top_mode(top_mode), .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Move pin at a falling edge with counter base; returns after 3rd rising edge.
  task automatic pin_move(input logic lvl, input int base, input logic clr_last,
                          output logic early_flag);
    cap_pin = lvl; cnt = W'(base);
    step();
    cnt = W'(base + 1);
    step();
    early_flag = cap_flag;
    cnt = W'(base + 2);
    flag_clr = clr_last;
    step();
    flag_clr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R9", "cap_value", int'(cap_value), 0);
    chk("R9", "cap_flag", int'(cap_flag), 0);
    chk("R9", "irq", int'(irq), 0);
  endtask

  task automatic t_rise();
    logic e;
    rise_sel = 1'b1; irq_en = 1'b1;
    pin_move(1'b1, 100, 1'b0, e);
    chk("R3", "flag early", int'(e), 0);
    chk("R2", "flag", int'(cap_flag), 1);
    chk("R3", "value", int'(cap_value), 102);
    chk("R6", "irq with flag", int'(irq), 1);
    clear_flag();
    chk("R4", "flag after clear", int'(cap_flag), 0);
    chk("R4", "value kept", int'(cap_value), 102);
    chk("R6", "irq after clear", int'(irq), 0);
    pin_move(1'b0, 200, 1'b0, e);
    step(); step();
    chk("R2", "falling ignored flag", int'(cap_flag), 0);
    chk("R2", "falling ignored value", int'(cap_value), 102);
  endtask

  task automatic t_fall();
    logic e;
    rise_sel = 1'b0;
    pin_move(1'b1, 300, 1'b0, e);
    step(); step();
    chk("R1", "rising ignored flag", int'(cap_flag), 0);
    pin_move(1'b0, 400, 1'b0, e);
    chk("R1", "flag", int'(cap_flag), 1);
    chk("R1", "value", int'(cap_value), 402);
    step(); step();
    chk("R4", "flag sticky", int'(cap_flag), 1);
    clear_flag();
  endtask

  task automatic t_sel_change();
    logic e;
    rise_sel = 1'b1;
    step(); step(); step(); step();
    chk("R8", "no capture flag", int'(cap_flag), 0);
    chk("R8", "no capture value", int'(cap_value), 402);
    pin_move(1'b1, 500, 1'b0, e);
    chk("R8", "new polarity value", int'(cap_value), 502);
    clear_flag();
  endtask

  task automatic t_race();
    logic e;
    rise_sel = 1'b0;
    pin_move(1'b0, 600, 1'b1, e);
    chk("R5", "flag wins over clear", int'(cap_flag), 1);
    chk("R5", "value", int'(cap_value), 602);
    clear_flag();
    chk("R4", "flag cleared", int'(cap_flag), 0);
  endtask

  task automatic t_top();
    logic e;
    rise_sel = 1'b1; top_mode = 1'b1;
    pin_move(1'b1, 700, 1'b0, e);
    step(); step();
    chk("R7", "flag blocked", int'(cap_flag), 0);
    chk("R7", "value blocked", int'(cap_value), 602);
    top_mode = 1'b0;
    pin_move(1'b0, 750, 1'b0, e);
    pin_move(1'b1, 800, 1'b0, e);
    chk("R7", "capture resumes", int'(cap_value), 802);
    clear_flag();
  endtask

  task automatic t_irq_en();
    logic e;
    irq_en = 1'b0;
    pin_move(1'b0, 850, 1'b0, e);
    pin_move(1'b1, 900, 1'b0, e);
    chk("R6", "flag set", int'(cap_flag), 1);
    chk("R6", "irq masked", int'(irq), 0);
    irq_en = 1'b1;
    step();
    chk("R6", "irq after enable", int'(irq), 1);
    irq_en = 1'b0;
    step();
    chk("R6", "irq after disable", int'(irq), 0);
    chk("R6", "flag kept", int'(cap_flag), 1);
    clear_flag();
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_sel_change();
    t_race();
    t_top();
    t_irq_en();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule